// File: doc/BRIEF.md
# Indexed-Load Bank Window Latch

This block watches the processor bus of an 8-bit system and changes which SRAM bank each half of the 64KB address space maps to. Software switches banks by running a harmless load of the accumulator, absolute indexed by X, with $FFFF as its operand. The data read of that instruction lands at $FFFF+X. The low byte of that address, which equals X-1 modulo 256, is taken as a bank command. The byte the read returns is never used.

A single command loads two 3-bit window registers together. Command bits 0-2 set the window for the lower 32KB, and bits 3-5 set the window for the upper 32KB. Command bits 6-7 are ignored. The top address bit chooses which window register drives the extra SRAM address lines, so exactly one of the two is in use at any time.

The opcode byte is recognised only in a cycle where SYNC marks an opcode fetch. Bus cycles that are not enabled are skipped. If the indexed read crosses a page, the processor first performs a dummy read. In that case the command is taken from the final read.

Top module: `idxbank_latch`

## Requirements
- R1: While reset is high, both window registers clear to 0 at the clock edge, so `sram_xa` reads 0 for both halves.
- R2: The sequence opcode $BD fetched with `sync`=1, then operand bytes $FF and $FF, then a data read at $FFFF (X=0) loads command $FF. This makes both windows 7.
- R3: When X is non-zero, the data read at $FFFF+X crosses a page. The block skips the dummy read at {$FF, X-1} and loads the command from the final read at {$00, X-1}.
- R4: Command bits [2:0] load the low-half window. Command bits [5:3] load the high-half window. Command bits [7:6] have no effect.
- R5: `sram_xa` shows the low-half window when `addr[15]`=0 and the high-half window when `addr[15]`=1.
- R6: If either operand byte differs from $FF, the detector disarms and the windows stay unchanged.
- R7: An opcode byte $BD seen while `sync`=0 does not start a detection.
- R8: Cycles with `bus_en`=0 are ignored. Inserting such cycles anywhere in the sequence does not change its outcome.
- R9: An opcode other than $BD, for example $B9, followed by $FF $FF and a read does not change the windows.
- R10: A `sync`=1 cycle that arrives while a sequence is armed abandons that sequence. The read that follows then has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync | input | 1 | High during an opcode fetch cycle |
| bus_en | input | 1 | High when the current bus cycle is valid |
| addr | input | 16 | Processor address bus |
| data | input | 8 | Processor data bus (value being read) |
| sram_xa | output | 3 | Extra SRAM address bits from the selected window |

## Verification
Several properties are checked on every cycle:
- the detector state does not move on a disabled bus cycle;
- a byte that is not an opcode fetch, or an opcode other than $BD, leaves the detector idle;
- the windows change only when a command is issued, and then take exactly the command's fields;
- exactly one window is enabled.

Other behaviours are visible only in the bench's scenarios: the page-crossing case, where the command must come from the second of two reads, and the ignored upper command bits. Abandoning a sequence on an unexpected opcode fetch, and the windows seen through both halves of the address space, are also scenario checks.

// File: rtl/idxbank_pkg.sv
package idxbank_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_OPL,
    ST_ARM,
    ST_FIX
  } det_state_t;
endpackage

// File: rtl/idxbank_detect.sv
module idxbank_detect
  import idxbank_pkg::*;
#(
  parameter int          ADDR_W = 16,
  parameter int          DATA_W = 8,
  parameter int          CMD_W  = 6,
  parameter logic [7:0]  OPCODE = 8'hBD
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync,
  input  logic              bus_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              cmd_valid,
  output logic [CMD_W-1:0]  cmd
);
  localparam logic [DATA_W-1:0] MARK = '1;
  localparam logic [ADDR_W-1:0] TOP  = '1;

  det_state_t state, state_nx;

  always_comb begin
    state_nx  = state;
    cmd_valid = 1'b0;
    if (bus_en) begin
      if (sync) begin
        state_nx = (data == DATA_W'(OPCODE)) ? ST_OPC : ST_IDLE;
      end else begin
        unique case (state)
          ST_OPC:  state_nx = (data == MARK) ? ST_OPL : ST_IDLE;
          ST_OPL:  state_nx = (data == MARK) ? ST_ARM : ST_IDLE;
          ST_ARM: begin
            // X = 0: single read at the top address, no fix-up
            if (addr == TOP) begin
              cmd_valid = 1'b1;
              state_nx  = ST_IDLE;
            end else begin
              state_nx  = ST_FIX;
            end
          end
          ST_FIX: begin
            cmd_valid = 1'b1;
            state_nx  = ST_IDLE;
          end
          default: state_nx = ST_IDLE;
        endcase
      end
    end
  end

  assign cmd = addr[CMD_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= state_nx;
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_en |=> $stable(state));

  // R7
  opcode_needs_sync_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_en && !sync && state == ST_IDLE) |=> state == ST_IDLE);

  // R9
  wrong_opcode_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_en && sync && data != DATA_W'(OPCODE)) |=> state == ST_IDLE);

  // R10
  sync_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_en && sync) |=> (state == ST_IDLE || state == ST_OPC));
endmodule

// File: rtl/idxbank_windows.sv
module idxbank_windows #(
  parameter int WIN_W   = 3,
  parameter int NUM_WIN = 2,
  parameter int SEL_W   = 1,
  parameter int CMD_W   = NUM_WIN * WIN_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd,
  input  logic [SEL_W-1:0] sel,
  output logic [WIN_W-1:0] xa
);
  logic [NUM_WIN-1:0][WIN_W-1:0] win_q;
  logic [NUM_WIN-1:0]            win_en;

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    always_ff @(posedge clk) begin
      if (rst)            win_q[i] <= '0;
      else if (cmd_valid) win_q[i] <= cmd[i*WIN_W +: WIN_W];
    end
    assign win_en[i] = (sel == SEL_W'(i));
  end

  always_comb begin
    xa = '0;
    for (int k = 0; k < NUM_WIN; k++) begin
      if (win_en[k]) xa = xa | win_q[k];
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> win_q == '0);

  // R6
  no_spurious_update_chk: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> $stable(win_q));

  // R4
  load_map_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> win_q == $past(cmd));

  // R5
  one_window_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(win_en) == 1);
endmodule

// File: rtl/idxbank_latch.sv
module idxbank_latch #(
  parameter int         ADDR_W  = 16,
  parameter int         DATA_W  = 8,
  parameter int         WIN_W   = 3,
  parameter int         NUM_WIN = 2,
  parameter logic [7:0] OPCODE  = 8'hBD
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync,
  input  logic              bus_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic [WIN_W-1:0]  sram_xa
);
  localparam int SEL_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
  localparam int CMD_W = NUM_WIN * WIN_W;

  logic             cmd_valid;
  logic [CMD_W-1:0] cmd;

  idxbank_detect #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_W(CMD_W), .OPCODE(OPCODE)
  ) u_detect (
    .clk(clk), .rst(rst), .sync(sync), .bus_en(bus_en),
    .addr(addr), .data(data), .cmd_valid(cmd_valid), .cmd(cmd)
  );

  idxbank_windows #(
    .WIN_W(WIN_W), .NUM_WIN(NUM_WIN), .SEL_W(SEL_W), .CMD_W(CMD_W)
  ) u_windows (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd(cmd),
    .sel(addr[ADDR_W-1 -: SEL_W]), .xa(sram_xa)
  );
endmodule

// File: tb/idxbank_latch_tb.sv
`timescale 1ns/1ps
module idxbank_latch_tb;
  typedef struct {
    logic [2:0] v;
    string      tag;
  } exp_t;

  logic        clk = 0;
  logic        rst = 1;
  logic        sync = 0;
  logic        bus_en = 0;
  logic [15:0] addr = 16'h0000;
  logic [7:0]  data = 8'h00;
  logic [2:0]  sram_xa;

  logic        probe_on = 0;
  exp_t        exp_q[$];
  int          checks = 0;
  int          errs = 0;
  logic [2:0]  exp_lo = 0, exp_hi = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  idxbank_latch u_dut (
    .clk(clk), .rst(rst), .sync(sync), .bus_en(bus_en),
    .addr(addr), .data(data), .sram_xa(sram_xa)
  );

  // monitor: pops one expected item per probe cycle
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (probe_on && exp_q.size() > 0) begin
        exp_t it;
        it = exp_q.pop_front();
        checks++;
        if (sram_xa !== it.v) begin
          errs++;
          $display("FAIL %s: sram_xa=%0d expected %0d", it.tag, sram_xa, it.v);
        end
      end
    end
  end

  task automatic cyc(input logic s, input logic e, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    sync = s; bus_en = e; addr = a; data = d;
  endtask

  // R5: low window via addr 7FFF, high window via addr 8000
  task automatic probe(input string tag);
    @(negedge clk);
    sync = 0; bus_en = 0; addr = 16'h7FFF;
    exp_q.push_back('{exp_lo, {tag, " R5 low"}});
    probe_on = 1;
    @(negedge clk);
    addr = 16'h8000;
    exp_q.push_back('{exp_hi, {tag, " R5 high"}});
    @(negedge clk);
    probe_on = 0;
    bus_en = 0;
  endtask

  // LDA $FFFF,X with optional stall cycles between steps (R8)
  task automatic lda_ffff_x(input logic [7:0] x, input logic [7:0] opc,
                            input logic [7:0] op_lo, input logic stall);
    logic [7:0] lo;
    lo = x - 8'd1;
    cyc(1, 1, 16'h2000, opc);
    if (stall) cyc(0, 0, 16'h1234, 8'h00);
    cyc(0, 1, 16'h2001, op_lo);
    if (stall) cyc(0, 0, 16'hFFFF, 8'hBD);
    cyc(0, 1, 16'h2002, 8'hFF);
    if (stall) cyc(0, 0, 16'h0000, 8'hFF);
    if (x == 8'd0) begin
      cyc(0, 1, 16'hFFFF, 8'h5A);
    end else begin
      cyc(0, 1, {8'hFF, lo}, 8'h5A);   // dummy read, no carry yet (R3)
      if (stall) cyc(0, 0, 16'h0000, 8'h00);
      cyc(0, 1, {8'h00, lo}, 8'hA5);   // final read
    end
    cyc(0, 0, 16'h2003, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    probe("R1 reset");

    // R2 X=0: cmd FF -> 7/7
    lda_ffff_x(8'h00, 8'hBD, 8'hFF, 0);
    exp_lo = 3'd7; exp_hi = 3'd7;
    probe("R2 x=0");

    // R3/R4 X=2C: cmd 2B = 10_1011 -> lo 3, hi 5
    lda_ffff_x(8'h2C, 8'hBD, 8'hFF, 0);
    exp_lo = 3'd3; exp_hi = 3'd5;
    probe("R3 page cross");

    // R4 X=C1: cmd C0 -> upper bits ignored, 0/0
    lda_ffff_x(8'hC1, 8'hBD, 8'hFF, 0);
    exp_lo = 3'd0; exp_hi = 3'd0;
    probe("R4 bits 7:6 ignored");

    // R4 X=12: cmd 11 -> lo 1, hi 2
    lda_ffff_x(8'h12, 8'hBD, 8'hFF, 0);
    exp_lo = 3'd1; exp_hi = 3'd2;
    probe("R4 field map");

    // R6 operand FE -> no change
    lda_ffff_x(8'h40, 8'hBD, 8'hFE, 0);
    probe("R6 bad operand");

    // R7 BD without sync
    cyc(1, 1, 16'h3000, 8'hEA);
    cyc(0, 1, 16'h3001, 8'hBD);
    cyc(0, 1, 16'h3002, 8'hFF);
    cyc(0, 1, 16'h3003, 8'hFF);
    cyc(0, 1, 16'hFFFF, 8'h00);
    cyc(0, 0, 16'h3004, 8'h00);
    probe("R7 no sync");

    // R8 stalls inside sequence, X=1A: cmd 19 = 011_001 -> lo 1, hi 3
    lda_ffff_x(8'h1A, 8'hBD, 8'hFF, 1);
    exp_lo = 3'd1; exp_hi = 3'd3;
    probe("R8 stalls");

    // R9 other opcode
    lda_ffff_x(8'h08, 8'hB9, 8'hFF, 0);
    probe("R9 other opcode");

    // R10 sync while armed abandons
    cyc(1, 1, 16'h4000, 8'hBD);
    cyc(0, 1, 16'h4001, 8'hFF);
    cyc(0, 1, 16'h4002, 8'hFF);
    cyc(1, 1, 16'h4003, 8'hA9);
    cyc(0, 1, 16'h003F, 8'h00);
    cyc(0, 1, 16'h0000, 8'h00);
    cyc(0, 0, 16'h4005, 8'h00);
    probe("R10 abandon");

    // R1 reset mid-run
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    exp_lo = 0; exp_hi = 0;
    probe("R1 reset again");

    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - errs, checks);
    $finish;
  end

  initial begin
    #80000;
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("%0d/%0d checks passed", checks - errs, checks);
      $finish;
    end
  end
endmodule